// File: doc/BRIEF.md
# NRZI Symbol Serializer

This block is the transmit datapath of a 125 Mbaud physical layer. It takes one 5-bit line-coded symbol per symbol period, shifts it out one bit per bit-clock cycle with the most significant bit first, and applies NRZI coding: a 1 flips the line level and a 0 leaves it where it is. The coded stream drives two pseudo-differential output pairs. One pair feeds the line and the other feeds a local loopback path. Each pair has its own active-low control that forces it to logical 0 (true output low, complement output high).

The whole block runs on the bit clock. A symbol strobe, asserted for one bit-clock cycle per symbol period, captures the parallel symbol. A free-running bit counter places the symbol boundary at which the shifter reloads, so the strobe sets only when data is captured. For production test, a test-mode select turns the transmitter-off input into a stepping clock: each rising edge of that input advances the datapath by one bit. In test mode the strobe also returns the bit counter to zero, which lets a tester line up symbol boundaries at will.

Top module: `nrzi_sym_serializer`

## Requirements
- R1: After reset the NRZI level is 0, and both pairs show logical 0 (`*_p`=0, `*_n`=1) until the first symbol captured after reset reaches the line.
- R2: A symbol captured on a clock edge where `sym_strobe`=1 is sent most significant bit first: bit 4, then 3, 2, 1, and 0 last.
- R3: The line level toggles for every 1 bit sent and holds for every 0 bit sent.
- R4: When `sym_strobe` is high on the first clock edge after reset release, that symbol's bit 4 shows on the outputs after the fifth edge that follows the capture edge. Each later bit follows one edge after the previous one.
- R5: With `sym_strobe` high on every fifth edge, consecutive symbols leave back to back with no gap or repeated bit.
- R6: In normal mode (`test_en`=0), `tx_off_n`=0 forces `line_p`=0 and `line_n`=1 at once. The coded stream keeps running underneath, and the main pair carries it again as soon as `tx_off_n` returns to 1.
- R7: `loop_en_n`=1 forces `loop_p`=0 and `loop_n`=1. `loop_en_n`=0 makes `loop_p` carry the same coded stream as the main pair, whatever the state of `tx_off_n`.
- R8: `line_n` is always the inverse of `line_p`, and `loop_n` is always the inverse of `loop_p`.
- R9: In test mode (`test_en`=1), `tx_off_n` never forces the main pair. The datapath advances one bit only on a clock edge where `tx_off_n` is 1 and was 0 on the previous edge.
- R10: In test mode a `sym_strobe` captures `sym_in` and clears the bit counter to 0. The symbol's bit 4 then appears on the sixth step after the strobe.
- R11: The bit counter never leaves the range 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (five times the symbol rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_strobe | input | 1 | One-cycle symbol strobe; captures `sym_in` |
| sym_in | input | 5 | Parallel coded symbol, bit 4 sent first |
| tx_off_n | input | 1 | Active-low main-pair force; stepping clock in test mode |
| loop_en_n | input | 1 | Active-low loopback pair enable |
| test_en | input | 1 | Test-mode select |
| line_p | output | 1 | Main pair, true output |
| line_n | output | 1 | Main pair, complement output |
| loop_p | output | 1 | Loopback pair, true output |
| loop_n | output | 1 | Loopback pair, complement output |

## Verification
The hardest condition to reach from the ports is the test-mode counter reinitialization. In normal mode the counter is never cleared, so a counter that ignores the strobe only shows up when the strobe falls out of phase with it. The bench therefore enters test mode, gives two stepping pulses on `tx_off_n` to move the counter away from zero, and only then strobes a symbol. A design that skips the clear releases bit 4 on the wrong step, and the bench catches the difference there. A second hard case is showing that the stream keeps running while the main pair is forced: the bench watches the loopback pair during the force window, and then checks the main pair's level once the force is released.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

   // Next NRZI line level: a one flips the level, a zero keeps it.
   function automatic logic nrzi_next(input logic level, input logic nrz_bit);
      return level ^ nrz_bit;
   endfunction

   // Logical zero on a pseudo-differential pair: true low, complement high.
   localparam logic PAIR_ZERO_P = 1'b0;

endpackage

// File: rtl/tx_ser_step_gen.sv
// Bit-step enable: every cycle in normal mode, on each rising edge of the
// test stepping input in test mode.
module tx_ser_step_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic test_en,
   input  logic tclk_in,
   output logic step
);
   logic tclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tclk_q <= 1'b1;
      else        tclk_q <= tclk_in;
   end

   assign step = test_en ? (tclk_in & ~tclk_q) : 1'b1;
endmodule

// File: rtl/tx_ser_bit_timer.sv
// Bit position counter; flags the symbol boundary at the last position.
module tx_ser_bit_timer #(
   parameter int SYM_W = 5,
   localparam int CNT_W = (SYM_W > 1) ? $clog2(SYM_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             sync_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             boundary
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (sync_clr) cnt <= '0;
      else if (step)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign boundary = step & ~sync_clr & (cnt == LAST);
endmodule

// File: rtl/tx_ser_shifter.sv
// Parallel-load shift register; the parameter picks the bit order.
module tx_ser_shifter #(
   parameter int SYM_W     = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [SYM_W-1:0] par_in,
   output logic             ser_bit
);
   logic [SYM_W-1:0] sh_q;
   logic [SYM_W-1:0] sh_next;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign ser_bit = sh_q[SYM_W-1];
         assign sh_next = {sh_q[SYM_W-2:0], 1'b0};
      end else begin : g_lsb_first
         assign ser_bit = sh_q[0];
         assign sh_next = {1'b0, sh_q[SYM_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    sh_q <= '0;
      else if (step) sh_q <= load ? par_in : sh_next;
   end
endmodule

// File: rtl/tx_ser_nrzi.sv
// NRZ to NRZI conversion register.
module tx_ser_nrzi
   import tx_ser_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic nrz_bit,
   output logic level
);
   always_ff @(posedge clk) begin
      if (!rst_n)    level <= 1'b0;
      else if (step) level <= nrzi_next(level, nrz_bit);
   end
endmodule

// File: rtl/tx_ser_out_pair.sv
// Pseudo-differential output pair with a force-to-zero control.
module tx_ser_out_pair
   import tx_ser_pkg::*;
(
   input  logic level,
   input  logic force_zero,
   output logic out_p,
   output logic out_n
);
   assign out_p = force_zero ? PAIR_ZERO_P : level;
   assign out_n = ~out_p;
endmodule

// File: rtl/nrzi_sym_serializer.sv
module nrzi_sym_serializer #(
   parameter int SYM_W     = 5,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CNT_W    = (SYM_W > 1) ? $clog2(SYM_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_strobe,
   input  logic [SYM_W-1:0] sym_in,
   input  logic             tx_off_n,
   input  logic             loop_en_n,
   input  logic             test_en,
   output logic             line_p,
   output logic             line_n,
   output logic             loop_p,
   output logic             loop_n
);
   generate
      if (SYM_W < 2) begin : g_bad_width
         $error("nrzi_sym_serializer: SYM_W must be at least 2");
      end
   endgenerate

   logic             step;
   logic             boundary;
   logic [CNT_W-1:0] bit_cnt;
   logic [SYM_W-1:0] sym_q;
   logic             ser_bit;
   logic             nrzi_q;
   logic             main_force;

   // Input register: capture on the symbol strobe.
   always_ff @(posedge clk) begin
      if (!rst_n)          sym_q <= '0;
      else if (sym_strobe) sym_q <= sym_in;
   end

   tx_ser_step_gen u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_en (test_en),
      .tclk_in (tx_off_n),
      .step    (step)
   );

   tx_ser_bit_timer #(.SYM_W(SYM_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .sync_clr (test_en & sym_strobe),
      .cnt      (bit_cnt),
      .boundary (boundary)
   );

   tx_ser_shifter #(.SYM_W(SYM_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .load    (boundary),
      .par_in  (sym_q),
      .ser_bit (ser_bit)
   );

   tx_ser_nrzi u_nrzi (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .nrz_bit (ser_bit),
      .level   (nrzi_q)
   );

   assign main_force = ~test_en & ~tx_off_n;

   tx_ser_out_pair u_main_pair (
      .level      (nrzi_q),
      .force_zero (main_force),
      .out_p      (line_p),
      .out_n      (line_n)
   );

   tx_ser_out_pair u_loop_pair (
      .level      (nrzi_q),
      .force_zero (loop_en_n),
      .out_p      (loop_p),
      .out_n      (loop_n)
   );
endmodule

// File: rtl/nrzi_sym_serializer_chk.sv
module nrzi_sym_serializer_chk #(
   parameter int SYM_W = 5,
   localparam int CNT_W = (SYM_W > 1) ? $clog2(SYM_W) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_en,
   input logic             tx_off_n,
   input logic             loop_en_n,
   input logic             line_p,
   input logic             line_n,
   input logic             loop_p,
   input logic             loop_n,
   input logic             step,
   input logic             ser_bit,
   input logic             nrzi_q,
   input logic [CNT_W-1:0] bit_cnt
);
   // R6
   main_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_en && !tx_off_n) |-> (line_p == 1'b0 && line_n == 1'b1));

   // R7
   loop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en_n |-> (loop_p == 1'b0 && loop_n == 1'b1));

   // R7
   loop_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_en_n && (test_en || tx_off_n)) |-> (loop_p == line_p));

   // R3
   nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(step) |-> ((nrzi_q ^ $past(nrzi_q)) == $past(ser_bit)));

   // R9
   nrzi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(step) |-> $stable(nrzi_q));

   // R11
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(SYM_W - 1));
endmodule

bind nrzi_sym_serializer nrzi_sym_serializer_chk #(.SYM_W(SYM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_en   (test_en),
   .tx_off_n  (tx_off_n),
   .loop_en_n (loop_en_n),
   .line_p    (line_p),
   .line_n    (line_n),
   .loop_p    (loop_p),
   .loop_n    (loop_n),
   .step      (step),
   .ser_bit   (ser_bit),
   .nrzi_q    (nrzi_q),
   .bit_cnt   (bit_cnt)
);

// File: tb/nrzi_sym_serializer_tb.sv
`timescale 1ns/1ps
module nrzi_sym_serializer_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       sym_strobe;
   logic [4:0] sym_in;
   logic       tx_off_n;
   logic       loop_en_n;
   logic       test_en;
   logic       line_p, line_n, loop_p, loop_n;

   int checks = 0;
   int errors = 0;
   logic [4:0] syms [0:7];

   always #2.5 clk = ~clk;

   nrzi_sym_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .sym_in(sym_in),
      .tx_off_n(tx_off_n), .loop_en_n(loop_en_n), .test_en(test_en),
      .line_p(line_p), .line_n(line_n), .loop_p(loop_p), .loop_n(loop_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic tmode, input logic toff);
      rst_n = 1'b0; sym_strobe = 1'b0; sym_in = '0;
      test_en = tmode; tx_off_n = toff; loop_en_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1: reset state and idle until a symbol is sent
   task automatic t_reset;
      do_reset(1'b0, 1'b1);
      chk("R1 line_p after reset", line_p, 1'b0);
      chk("R1 line_n after reset", line_n, 1'b1);
      chk("R1 loop_p after reset", loop_p, 1'b0);
      chk("R8 loop_n after reset", loop_n, 1'b1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R1 line_p idle", line_p, 1'b0);
      end
   endtask

   // R2 R3 R4 R5 R6 R7 R8: continuous stream with optional forcing windows
   task automatic t_stream(input int nsym, input int off_from, input int off_to,
                           input logic lb_n);
      logic exp_lvl;
      do_reset(1'b0, 1'b1);
      loop_en_n = lb_n;
      exp_lvl = 1'b0;
      for (int c = 0; c < nsym * 5 + 6; c++) begin
         sym_strobe = (c % 5 == 0) && (c / 5 < nsym);
         sym_in     = sym_strobe ? syms[c / 5] : 5'h00;
         tx_off_n   = !(c >= off_from && c < off_to);
         @(posedge clk);
         @(negedge clk);
         begin
            int j = c - 5;
            if (j >= 0 && j < nsym * 5)
               exp_lvl = exp_lvl ^ syms[j / 5][4 - (j % 5)];
         end
         chk(tx_off_n ? "R2 R3 R4 R5 line_p stream" : "R6 line_p forced",
             line_p, tx_off_n ? exp_lvl : 1'b0);
         chk("R8 line_n inverse", line_n, ~line_p);
         chk(lb_n ? "R7 loop_p forced" : "R7 R6 loop_p carries stream",
             loop_p, lb_n ? 1'b0 : exp_lvl);
         chk("R8 loop_n inverse", loop_n, ~loop_p);
      end
      sym_strobe = 1'b0;
      tx_off_n   = 1'b1;
   endtask

   task automatic tpulse;
      tx_off_n = 1'b1;
      @(negedge clk);
      tx_off_n = 1'b0;
      @(negedge clk);
   endtask

   // R9 R10: test-mode stepping and counter clear by the strobe
   task automatic t_testmode;
      logic [4:0] exp_seq;
      do_reset(1'b1, 1'b0);
      exp_seq = 5'b11011;  // levels after bits of 10110: 1,1,0,1,1
      repeat (3) @(negedge clk);
      chk("R9 no step without pulses", line_p, 1'b0);
      tpulse(); tpulse();   // counter moved away from zero
      chk("R9 line_p idle steps", line_p, 1'b0);
      sym_strobe = 1'b1; sym_in = 5'b10110;
      @(negedge clk);
      sym_strobe = 1'b0; sym_in = '0;
      repeat (4) @(negedge clk);
      chk("R9 hold without pulses", line_p, 1'b0);
      for (int s = 1; s <= 10; s++) begin
         tpulse();
         if (s <= 5)
            chk("R10 no early bit after strobe", line_p, 1'b0);
         else
            chk("R9 R10 stepped bit, tx_off_n low not forcing", line_p, exp_seq[10 - s]);
         chk("R7 loop_p follows in test mode", loop_p, line_p);
      end
      repeat (3) @(negedge clk);
      chk("R9 level held between pulses", line_p, 1'b1);
      test_en = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      syms[0] = 5'b11111; syms[1] = 5'b00000; syms[2] = 5'b10101; syms[3] = 5'b01010;
      syms[4] = 5'b11000; syms[5] = 5'b00011; syms[6] = 5'b10110; syms[7] = 5'b01101;
      t_reset();
      t_stream(8, 0, 0, 1'b0);     // plain stream, loopback on
      t_stream(8, 12, 23, 1'b0);   // main pair forced mid-stream
      t_stream(4, 0, 0, 1'b1);     // loopback pair forced
      t_testmode();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule